// File: doc/BRIEF.md
# Recursive Crosswise Binary Multiplier

This block multiplies two unsigned operands and returns the full double-width product with no truncation. The default width is 32 bits, giving a 64-bit result. The multiplier is built by recursive quartering. At each level, both operands are split into an upper and a lower half. Four half-width products are formed: high×high, high×low, low×high and low×low. These are merged with parallel-prefix adders.

The recursion stops at small leaf tiles. Each leaf forms its product column by column. Column k is the count of all bit pairs a[i]&b[j] with i+j=k, plus the carry from column k-1. No shifted partial-product rows are ever built. With the defaults, the 32-bit top is made from four 16-bit nodes, and each 16-bit node from four 8-bit leaves.

An optional output register, selected by a parameter, lets the block sit on a timing-critical path. Without it, the path from operands to product is purely combinational.

Top module: `vc_mul_top`

## Requirements
- R1: For every pair of unsigned operands, prod_o equals op_a_i × op_b_i over all 2·WIDTH bits; in particular bit 0 equals op_a_i[0] & op_b_i[0].
- R2: If either operand is zero, the product is zero.
- R3: If op_a_i equals one, the product equals op_b_i zero-extended to 2·WIDTH bits.
- R4: If both operands are below 2^(WIDTH/2), the upper WIDTH bits of the product are zero.
- R5: If both operands are all ones, the product is 2^(2·WIDTH) − 2^(WIDTH+1) + 1, with no bit lost.
- R6: With OUT_REG=1, the product of the operands present at a rising edge of clk_i appears after that edge. It holds unchanged until the next rising edge, even if the operands change in between.
- R7: With OUT_REG=1, rst_ni low clears prod_o to zero at once, without waiting for a clock edge.
- R8: With OUT_REG=0, prod_o follows the current operands combinationally, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | WIDTH | Unsigned multiplicand |
| op_b_i | input | WIDTH | Unsigned multiplier |
| prod_o | output | 2·WIDTH | Unsigned product |

## Verification
A small 8-bit build with 2-bit leaves gets every operand pair. This exercises two merge levels, and every carry path through both prefix adders, with no gaps. The registered 32-bit build gets zero, one, all ones, alternating-bit and narrow operands, plus random pairs. These vectors separate an error in the crosswise columns from an error in the way the middle sum is shifted and carried into the upper half. Checking the output between the operand change and the next edge shows whether the register really holds its value.

// File: rtl/vc_mul_pkg.sv
package vc_mul_pkg;
  // number of prefix levels for a w-bit adder
  function automatic int ks_levels(input int w);
    int n;
    n = 0;
    while ((1 << n) < w) n++;
    return (n < 1) ? 1 : n;
  endfunction
endpackage

// File: rtl/vc_mul_leaf.sv
module vc_mul_leaf #(
  parameter int LW = 8
) (
  input  logic [LW-1:0]   a_i,
  input  logic [LW-1:0]   b_i,
  output logic [2*LW-1:0] p_o
);
  localparam int CW = $clog2(LW) + 2;

  always_comb begin
    logic [CW-1:0] col;
    logic [CW-1:0] cy;
    cy = '0;
    p_o = '0;
    for (int k = 0; k < 2*LW-1; k++) begin
      col = cy;
      for (int i = 0; i < LW; i++) begin
        if (k - i >= 0 && k - i < LW)
          col = col + CW'(a_i[i] & b_i[k-i]);
      end
      p_o[k] = col[0];
      cy = col >> 1;
    end
    p_o[2*LW-1] = cy[0];
  end
endmodule

// File: rtl/vc_ks_adder.sv
module vc_ks_adder
  import vc_mul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  localparam int LV = ks_levels(W);

  logic [LV:0][W-1:0] g;
  logic [LV:0][W-1:0] p;
  logic unused_p;

  assign g[0] = x_i & y_i;
  assign p[0] = x_i ^ y_i;

  for (genvar s = 0; s < LV; s++) begin : g_lvl
    localparam int D = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_cmb
        assign g[s+1][i] = g[s][i] | (p[s][i] & g[s][i-D]);
        assign p[s+1][i] = p[s][i] & p[s][i-D];
      end else begin : g_pass
        assign g[s+1][i] = g[s][i];
        assign p[s+1][i] = p[s][i];
      end
    end
  end

  if (W > 1) begin : g_sum
    assign s_o = p[0] ^ {g[LV][W-2:0], 1'b0};
  end else begin : g_sum1
    assign s_o = p[0];
  end
  assign co_o = g[LV][W-1];
  assign unused_p = ^p[LV];
endmodule

// File: rtl/vc_mul_node.sv
module vc_mul_node #(
  parameter int W  = 32,
  parameter int LW = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  if (W <= LW) begin : g_leaf
    vc_mul_leaf #(.LW(W)) u_leaf (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    localparam int H = W / 2;
    logic [W-1:0]   pp_hh, pp_hl, pp_lh, pp_ll;
    logic [W-1:0]   mid_s;
    logic           mid_c;
    logic [2*W-1:0] mid_sh;
    logic           unused_co;

    vc_mul_node #(.W(H), .LW(LW)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(pp_hh));
    vc_mul_node #(.W(H), .LW(LW)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(pp_hl));
    vc_mul_node #(.W(H), .LW(LW)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(pp_lh));
    vc_mul_node #(.W(H), .LW(LW)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(pp_ll));

    // cross terms, W+1 bits wide
    vc_ks_adder #(.W(W)) u_mid (
      .x_i(pp_hl), .y_i(pp_lh), .s_o(mid_s), .co_o(mid_c)
    );

    assign mid_sh = (2*W)'({mid_c, mid_s}) << H;

    // concatenated outer terms plus shifted middle; never overflows 2W bits
    vc_ks_adder #(.W(2*W)) u_fin (
      .x_i({pp_hh, pp_ll}), .y_i(mid_sh), .s_o(p_o), .co_o(unused_co)
    );
  end
endmodule

// File: rtl/vc_mul_top.sv
module vc_mul_top #(
  parameter int WIDTH   = 32,
  parameter int LEAF_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   op_a_i,
  input  logic [WIDTH-1:0]   op_b_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;
  localparam int HW = WIDTH / 2;
  localparam logic [PW-1:0] ONES_SQ = {{(WIDTH-1){1'b1}}, 1'b0, {(WIDTH-1){1'b0}}, 1'b1};

  logic [PW-1:0] prod_c;

  vc_mul_node #(.W(WIDTH), .LW(LEAF_W)) u_root (
    .a_i(op_a_i), .b_i(op_b_i), .p_o(prod_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_o <= '0;
      else         prod_o <= prod_c;
    end

    p_lsb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> prod_o[0] == $past(op_a_i[0] & op_b_i[0]));
    p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i == '0 || op_b_i == '0) |=> prod_o == '0);
    p_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i == WIDTH'(1)) |=> prod_o == PW'($past(op_b_i)));
    p_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i[WIDTH-1:HW] == '0 && op_b_i[WIDTH-1:HW] == '0) |=> prod_o[PW-1:WIDTH] == '0);
    p_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&op_a_i && &op_b_i) |=> prod_o == ONES_SQ);
  end else begin : g_comb
    assign prod_o = prod_c;

    p_lsb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_o[0] == (op_a_i[0] & op_b_i[0]));
    p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i == '0 || op_b_i == '0) |-> prod_o == '0);
    p_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i == WIDTH'(1)) |-> prod_o == PW'(op_b_i));
    p_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_a_i[WIDTH-1:HW] == '0 && op_b_i[WIDTH-1:HW] == '0) |-> prod_o[PW-1:WIDTH] == '0);
    p_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&op_a_i && &op_b_i) |-> prod_o == ONES_SQ);
  end
endmodule

// File: tb/sim_vc_mul_top.sv
`timescale 1ns/1ps
module sim_vc_mul_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] p32;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vc_mul_top #(.WIDTH(32), .LEAF_W(8), .OUT_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a32), .op_b_i(b32), .prod_o(p32)
  );
  vc_mul_top #(.WIDTH(8), .LEAF_W(2), .OUT_REG(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a8), .op_b_i(b8), .prod_o(p8)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  logic [63:0] last_exp = '0;

  // drive at negedge; hold check before the edge (R6), result after it
  task automatic run32(input string tag, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] e;
    e = {32'h0, a} * {32'h0, b};
    @(negedge clk);
    a32 = a; b32 = b;
    #1 chk("R6 hold", p32, last_exp);
    @(negedge clk);
    chk(tag, p32, e);
    last_exp = e;
  endtask

  initial begin
    #1 chk("R7 reset", p32, 64'h0);
    repeat (3) @(negedge clk);
    chk("R7 reset held", p32, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 after release", p32, 64'h0);

    run32("R2 zero a", 32'h0, 32'hDEAD_BEEF);
    run32("R2 zero b", 32'h1234_5678, 32'h0);
    run32("R3 one", 32'h1, 32'hFFFF_FFFE);
    run32("R3 one b", 32'h1, 32'h8000_0001);
    run32("R5 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R5 const", p32, 64'hFFFF_FFFE_0000_0001);
    run32("R1 alt", 32'hAAAA_AAAA, 32'h5555_5555);
    run32("R1 alt2", 32'h5555_5555, 32'h5555_5555);
    run32("R1 alt3", 32'hAAAA_AAAA, 32'hAAAA_AAAA);
    run32("R4 narrow", 32'h0000_FFFF, 32'h0000_FFFF);
    chk("R4 upper", {32'h0, p32[63:32]}, 64'h0);
    run32("R1 msb", 32'h8000_0000, 32'h8000_0000);
    run32("R1 mid carry", 32'h0001_FFFF, 32'hFFFF_0001);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 4 == 1) ra = ra & 32'h0000_FFFF;
      if (i % 4 == 2) rb = rb | 32'hFFFF_0000;
      run32("R1 random", ra, rb);
    end

    // exhaustive small build: two merge levels, combinational path
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk);
        a8 = 8'(x); b8 = 8'(y);
        #1 chk("R8 R1 exhaustive", {48'h0, p8}, 64'(x * y));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got running exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule